// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache with Table Fetch

This block translates virtual addresses into physical addresses for one requester. A small, fully associative array caches page mappings. Each slot holds a virtual page number, a frame number, two permission bits and the identifier of the address space that owns the mapping. A lookup matches only a slot whose page number and owner both equal the request's page number and the current address-space input. Mappings of several processes can therefore stay in the array across context switches.

A hit answers in the same cycle the request is presented. On a miss the block reads one page-table word from memory, at the table base plus the page number scaled by the size of one table word. It decodes that word and checks it against the access. A fault is returned without caching anything. An allowed word is written into the array. The still-pending request then hits on the next cycle and completes.

Requests and responses use valid/ready. The requester holds `req_valid`, the address, the access type and `cur_asid` steady until `req_ready`. `req_ready` rises exactly in the cycle the response is taken (`rsp_valid && rsp_ready`), so withholding `rsp_ready` stalls the request in place. The table-read port is valid/ready on the request side. Read data comes back on a single strobe with no back-pressure. Flush controls are plain one-cycle pulses.

Top module: `tlb_asid_walk`

## Requirements
- R1: On a hit with the access permitted, `rsp_valid` is high in the same cycle as `req_valid`. `rsp_fault` is 0, `rsp_paddr` equals the cached frame number shifted left by OFF_W with the request's low OFF_W address bits below it, and no table read is issued.
- R2: On a hit whose cached permissions refuse the access, the response carries `rsp_fault` = 2 with `rsp_paddr` = 0 and no table read. A write is refused when the write-permit bit is 0. A user-mode access is refused when the user-permit bit is 0.
- R3: A miss issues exactly one table read, at address `ptbase` + VPN × 2^PTE_SZ_LOG2.
- R4: The table word has valid in bit 0, write-permit in bit 1, user-permit in bit 2, and the frame number from bit 3 upward. A word with bit 0 clear yields `rsp_fault` = 1 and paddr 0, and it is not cached, so the same access reads the table again.
- R5: A valid word that refuses the access yields `rsp_fault` = 2 and paddr 0, and it is not cached.
- R6: A valid, permitting word is cached and the request completes as a hit. Later accesses to that page under the same address space need no table read.
- R7: A slot matches only when both its page number and its address-space tag equal the request's. The same page under another address space misses.
- R8: A `flush_all` pulse removes every cached mapping from the next cycle on.
- R9: A `flush_asid_en` pulse removes exactly the mappings tagged `flush_asid`. Other spaces keep theirs.
- R10: A new mapping goes into the lowest-numbered empty slot. When none is empty it replaces the slot named by a rotating pointer. The pointer starts at 0 after reset and advances by one, wrapping, on each such replacement.
- R11: At most one miss is handled at a time. While a table read is pending, no response is given and the request is not accepted. A table read request stays asserted, with a steady address, until `mem_req_ready`.
- R12: While `rsp_ready` is low, a valid response is held and `req_ready` stays low. The request is taken in the first cycle with `rsp_ready` high.
- R13: After reset no mapping is cached, and `rsp_valid`, `req_ready` and `mem_req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_asid | input | ASID_W | Address space of the current request |
| ptbase | input | MEM_AW | Byte address of the page table |
| flush_all | input | 1 | Pulse: drop all mappings |
| flush_asid_en | input | 1 | Pulse: drop mappings of `flush_asid` |
| flush_asid | input | ASID_W | Address space to drop |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Request taken this cycle |
| req_vaddr | input | VA_W | Virtual address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester accepts the response |
| rsp_paddr | output | PFN_W+OFF_W | Physical address, 0 on a fault |
| rsp_fault | output | 2 | 0 none, 1 invalid entry, 2 protection |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory takes the read |
| mem_req_addr | output | MEM_AW | Byte address of the table word |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | PFN_W+3 | Table word |

## Verification
The assertions take the request side to be well behaved. The address, access type, `cur_asid` and `ptbase` stay fixed from the rise of `req_valid` until `req_ready`. Read data arrives only for a read that was taken, once per read. Without these the single-match property could fail, because a mid-walk change of address space could insert a duplicate. The bench drives every request through one task that holds all of these fields until the handshake. It changes the address space and table base only between requests, and its memory model emits one data strobe a fixed latency after each accepted read.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_INVALID = 2'd1,
    FLT_PROT    = 2'd2
  } fault_e;

  typedef enum logic [1:0] {
    WS_LOOK,
    WS_MREQ,
    WS_MWAIT,
    WS_FAULT
  } walk_st_e;

  // True when the permission bits refuse the requested kind of access.
  function automatic logic perm_refused(input logic want_wr, input logic want_usr,
                                        input logic may_wr, input logic may_usr);
    return (want_wr && !may_wr) || (want_usr && !may_usr);
  endfunction

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int ASID_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              hit,
  output logic [PFN_W-1:0]  hit_pfn,
  output logic              hit_w,
  output logic              hit_u,
  input  logic              ins_en,
  input  logic [PFN_W-1:0]  ins_pfn,
  input  logic              ins_w,
  input  logic              ins_u,
  input  logic              flush_all,
  input  logic              flush_one,
  input  logic [ASID_W-1:0] flush_asid
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld_q;
  logic [ENTRIES-1:0] match;
  logic [ENTRIES-1:0] wr_sel;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [ASID_W-1:0]  asid_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q  [ENTRIES];
  logic [ENTRIES-1:0] w_q;
  logic [ENTRIES-1:0] u_q;
  logic [IDX_W-1:0]   rr_q;
  logic [IDX_W-1:0]   victim;
  logic               full;
  logic               flush_any;

  assign flush_any = flush_all | flush_one;
  assign full      = &vld_q;

  // One comparator per slot: page number and owner must both agree.
  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    assign match[i]  = vld_q[i] && (vpn_q[i] == lk_vpn) && (asid_q[i] == lk_asid);
    assign wr_sel[i] = ins_en && !flush_any && (victim == IDX_W'(i));
  end

  assign hit = |match;

  always_comb begin
    hit_pfn = '0;
    hit_w   = 1'b0;
    hit_u   = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        hit_pfn = hit_pfn | pfn_q[i];
        hit_w   = hit_w | w_q[i];
        hit_u   = hit_u | u_q[i];
      end
    end
  end

  // Lowest empty slot wins; a full array falls back to the rotating pointer.
  always_comb begin
    logic found;
    found  = 1'b0;
    victim = rr_q;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!found && !vld_q[i]) begin
        victim = IDX_W'(i);
        found  = 1'b1;
      end
    end
  end

  // A flush in the same cycle as an insert drops the insert; the pending
  // request then misses again and refetches.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (flush_all || (flush_one && asid_q[i] == flush_asid)) vld_q[i] <= 1'b0;
        else if (wr_sel[i])                                      vld_q[i] <= 1'b1;
      end
      if (ins_en && !flush_any && full)
        rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (wr_sel[i]) begin
        vpn_q[i]  <= lk_vpn;
        asid_q[i] <= lk_asid;
        pfn_q[i]  <= ins_pfn;
        w_q[i]    <= ins_w;
        u_q[i]    <= ins_u;
      end
    end
  end

  // R7: inserts happen only on a miss, so no two slots ever match at once.
  a_r7_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

  // R8: a full flush leaves nothing cached in the following cycle.
  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (vld_q == '0));

endmodule

// File: rtl/tlb_walker.sv
module tlb_walker
  import tlb_pkg::*;
#(
  parameter int VPN_W       = 20,
  parameter int PFN_W       = 20,
  parameter int MEM_AW      = 32,
  parameter int PTE_SZ_LOG2 = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [VPN_W-1:0]   req_vpn,
  input  logic               req_write,
  input  logic               req_user,
  input  logic               lk_hit,
  input  logic               rsp_ready,
  input  logic [MEM_AW-1:0]  ptbase,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [MEM_AW-1:0]  mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [PFN_W+2:0]   mem_rsp_data,
  output walk_st_e           st,
  output fault_e             flt,
  output logic               ins_en,
  output logic [PFN_W-1:0]   ins_pfn,
  output logic               ins_w,
  output logic               ins_u
);

  walk_st_e          st_q;
  fault_e            flt_q;
  logic [MEM_AW-1:0] addr_q;
  logic              pte_v;
  logic              pte_deny;

  assign pte_v    = mem_rsp_data[0];
  assign ins_w    = mem_rsp_data[1];
  assign ins_u    = mem_rsp_data[2];
  assign ins_pfn  = mem_rsp_data[PFN_W+2:3];
  assign pte_deny = perm_refused(req_write, req_user, ins_w, ins_u);

  assign st            = st_q;
  assign flt           = flt_q;
  assign mem_req_valid = (st_q == WS_MREQ);
  assign mem_req_addr  = addr_q;
  assign ins_en        = (st_q == WS_MWAIT) && mem_rsp_valid && pte_v && !pte_deny;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WS_LOOK;
      flt_q  <= FLT_NONE;
      addr_q <= '0;
    end else begin
      unique case (st_q)
        WS_LOOK: begin
          if (req_valid && !lk_hit) begin
            st_q   <= WS_MREQ;
            addr_q <= ptbase + (MEM_AW'(req_vpn) << PTE_SZ_LOG2);
          end
        end
        WS_MREQ: begin
          if (mem_req_ready) st_q <= WS_MWAIT;
        end
        WS_MWAIT: begin
          if (mem_rsp_valid) begin
            if (!pte_v) begin
              st_q  <= WS_FAULT;
              flt_q <= FLT_INVALID;
            end else if (pte_deny) begin
              st_q  <= WS_FAULT;
              flt_q <= FLT_PROT;
            end else begin
              st_q  <= WS_LOOK;   // retry: the next lookup hits
            end
          end
        end
        WS_FAULT: begin
          if (rsp_ready) begin
            st_q  <= WS_LOOK;
            flt_q <= FLT_NONE;
          end
        end
        default: st_q <= WS_LOOK;
      endcase
    end
  end

  // R11: a table read stays up with a steady address until memory takes it.
  a_r11_read_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

endmodule

// File: rtl/tlb_asid_walk.sv
module tlb_asid_walk
  import tlb_pkg::*;
#(
  parameter int ENTRIES     = 8,
  parameter int VA_W        = 32,
  parameter int OFF_W       = 12,
  parameter int PFN_W       = 20,
  parameter int ASID_W      = 8,
  parameter int MEM_AW      = 32,
  parameter int PTE_SZ_LOG2 = 2,
  localparam int VPN_W      = VA_W - OFF_W,
  localparam int PA_W       = PFN_W + OFF_W,
  localparam int PTE_W      = PFN_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic [MEM_AW-1:0] ptbase,
  input  logic              flush_all,
  input  logic              flush_asid_en,
  input  logic [ASID_W-1:0] flush_asid,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_write,
  input  logic              req_user,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [1:0]        rsp_fault,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [MEM_AW-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [PTE_W-1:0]  mem_rsp_data
);

  logic [VPN_W-1:0] req_vpn;
  logic             hit;
  logic [PFN_W-1:0] hit_pfn;
  logic             hit_w;
  logic             hit_u;
  logic             ins_en;
  logic [PFN_W-1:0] ins_pfn;
  logic             ins_w;
  logic             ins_u;
  walk_st_e         st;
  fault_e           flt;
  fault_e           fault_now;
  logic             hit_deny;

  assign req_vpn = req_vaddr[VA_W-1:OFF_W];

  tlb_cam #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .PFN_W   (PFN_W),
    .ASID_W  (ASID_W)
  ) cam_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_vpn     (req_vpn),
    .lk_asid    (cur_asid),
    .hit        (hit),
    .hit_pfn    (hit_pfn),
    .hit_w      (hit_w),
    .hit_u      (hit_u),
    .ins_en     (ins_en),
    .ins_pfn    (ins_pfn),
    .ins_w      (ins_w),
    .ins_u      (ins_u),
    .flush_all  (flush_all),
    .flush_one  (flush_asid_en),
    .flush_asid (flush_asid)
  );

  tlb_walker #(
    .VPN_W       (VPN_W),
    .PFN_W       (PFN_W),
    .MEM_AW      (MEM_AW),
    .PTE_SZ_LOG2 (PTE_SZ_LOG2)
  ) walk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_vpn       (req_vpn),
    .req_write     (req_write),
    .req_user      (req_user),
    .lk_hit        (hit),
    .rsp_ready     (rsp_ready),
    .ptbase        (ptbase),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .st            (st),
    .flt           (flt),
    .ins_en        (ins_en),
    .ins_pfn       (ins_pfn),
    .ins_w         (ins_w),
    .ins_u         (ins_u)
  );

  assign hit_deny = perm_refused(req_write, req_user, hit_w, hit_u);

  // Responses come from the held request: a hit while idle, or a fault
  // latched by the walker.
  assign rsp_valid = req_valid && (((st == WS_LOOK) && hit) || (st == WS_FAULT));
  assign fault_now = (st == WS_FAULT) ? flt : (hit_deny ? FLT_PROT : FLT_NONE);
  assign rsp_fault = fault_now;
  assign rsp_paddr = (fault_now == FLT_NONE) ? {hit_pfn, req_vaddr[OFF_W-1:0]} : '0;
  assign req_ready = rsp_valid && rsp_ready;

  // R1: a good translation keeps the page offset untouched.
  a_r1_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 2'd0) |-> (rsp_paddr[OFF_W-1:0] == req_vaddr[OFF_W-1:0]));

  // R11: no response while a table read is still being requested.
  a_r11_quiet_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !rsp_valid);

  // R6: a mapping is written only when the lookup missed.
  a_r6_insert_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |-> !hit);

endmodule

// File: tb/tlb_asid_walk_tb.sv
`timescale 1ns/1ps
module tlb_asid_walk_tb_top;

  localparam int ENT = 4;
  localparam int VA  = 8;
  localparam int OFF = 4;
  localparam int PFN = 5;
  localparam int AS  = 2;
  localparam int MAW = 16;
  localparam int PSZ = 1;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [AS-1:0]  cur_asid = '0;
  logic [MAW-1:0] ptbase = 16'h0040;
  logic           flush_all = 1'b0;
  logic           flush_asid_en = 1'b0;
  logic [AS-1:0]  flush_asid = '0;
  logic           req_valid = 1'b0;
  logic           req_ready;
  logic [VA-1:0]  req_vaddr = '0;
  logic           req_write = 1'b0;
  logic           req_user = 1'b0;
  logic           rsp_valid;
  logic           rsp_ready = 1'b1;
  logic [PFN+OFF-1:0] rsp_paddr;
  logic [1:0]     rsp_fault;
  logic           mem_req_valid;
  logic           mem_req_ready = 1'b0;
  logic [MAW-1:0] mem_req_addr;
  logic           mem_rsp_valid = 1'b0;
  logic [PFN+2:0] mem_rsp_data = '0;

  always #2.5 clk = ~clk;

  tlb_asid_walk #(
    .ENTRIES(ENT), .VA_W(VA), .OFF_W(OFF), .PFN_W(PFN), .ASID_W(AS),
    .MEM_AW(MAW), .PTE_SZ_LOG2(PSZ)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .cur_asid(cur_asid), .ptbase(ptbase),
    .flush_all(flush_all), .flush_asid_en(flush_asid_en), .flush_asid(flush_asid),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  int checks = 0;
  int failures = 0;
  int mem_reads = 0;
  int mem_cyc = 0;
  int mem_cnt = 0;
  logic [MAW-1:0] mem_last = '0;

  // Reference contents of the cache, kept from the requirements.
  logic           m_v    [ENT];
  logic [3:0]     m_vpn  [ENT];
  logic [AS-1:0]  m_asid [ENT];
  logic [PFN-1:0] m_pfn  [ENT];
  logic           m_w    [ENT];
  logic           m_u    [ENT];
  int             m_rr = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Page table contents for a given page and table base.
  function automatic logic [PFN+2:0] pte_of(input int vpn, input logic [MAW-1:0] base);
    logic v, w, u;
    logic [PFN-1:0] f;
    v = (vpn % 5) != 4;
    w = (vpn % 3) != 0;
    u = vpn[1];
    f = PFN'((vpn * 3 + int'(base[8:4])) % 32);
    return {f, u, w, v};
  endfunction

  // Memory model: ready stalls one cycle in three, data two cycles later.
  initial begin
    forever begin
      @(negedge clk);
      mem_cyc++;
      mem_rsp_valid = 1'b0;
      if (mem_cnt > 0) begin
        mem_cnt--;
        if (mem_cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = pte_of(int'((mem_last - ptbase) >> PSZ), ptbase);
        end
      end
      mem_req_ready = (mem_cyc % 3) != 1;
      if (mem_req_valid && mem_req_ready) begin
        mem_last = mem_req_addr;
        mem_reads++;
        mem_cnt = 2;
      end
    end
  end

  task automatic access(input int vpn, input int off, input bit wr, input bit usr,
                        input bit bp, input string tag);
    int hi, ew, cyc, r0, exp_addr;
    bit got, held;
    logic [1:0] ef, af;
    logic [PFN-1:0] epfn;
    logic [PFN+2:0] pte;
    logic [PFN+OFF-1:0] ep, ap;
    hi = -1;
    for (int i = 0; i < ENT; i++)
      if (m_v[i] && m_vpn[i] == 4'(vpn) && m_asid[i] == cur_asid) hi = i;
    exp_addr = int'(ptbase) + vpn * 2;
    if (hi >= 0) begin
      ew = 0;
      epfn = m_pfn[hi];
      ef = ((wr && !m_w[hi]) || (usr && !m_u[hi])) ? 2'd2 : 2'd0;
    end else begin
      ew = 1;
      pte = pte_of(vpn, ptbase);
      epfn = pte[PFN+2:3];
      if (!pte[0]) ef = 2'd1;
      else if ((wr && !pte[1]) || (usr && !pte[2])) ef = 2'd2;
      else ef = 2'd0;
    end
    ep = (ef == 2'd0) ? {epfn, 4'(off)} : '0;

    @(negedge clk);
    req_vaddr = {4'(vpn), 4'(off)};
    req_write = wr;
    req_user  = usr;
    req_valid = 1'b1;
    rsp_ready = !bp;
    r0 = mem_reads;
    cyc = 0; got = 0; held = 0; af = '0; ap = '0;
    while (!got && cyc < 60) begin
      #1;
      if (mem_req_valid && (rsp_valid || req_ready))
        chk(0, "R11", "response during table read", 1, 0);
      if (rsp_valid && !rsp_ready) begin
        held = 1;
        if (req_ready) chk(0, "R12", "req_ready while stalled", 1, 0);
      end
      if (rsp_valid && rsp_ready) begin
        got = 1; af = rsp_fault; ap = rsp_paddr;
      end else begin
        @(negedge clk);
        cyc++;
        if (bp && cyc >= 2) rsp_ready = 1'b1;
      end
    end
    @(negedge clk);
    req_valid = 1'b0;
    rsp_ready = 1'b1;

    chk(got, tag, "response seen", int'(got), 1);
    chk(af == ef, tag, "fault code", int'(af), int'(ef));
    chk(ap == ep, tag, "paddr", int'(ap), int'(ep));
    chk(mem_reads - r0 == ew, tag, "table reads", mem_reads - r0, ew);
    if (ew == 1) chk(int'(mem_last) == exp_addr, "R3", "table address", int'(mem_last), exp_addr);
    if (ew == 0 && !bp) chk(cyc == 0, "R1", "hit latency", cyc, 0);
    if (ew == 0 && bp) begin
      chk(held, "R12", "response held under stall", int'(held), 1);
      chk(cyc == 2, "R12", "accept cycle", cyc, 2);
    end

    if (ew == 1 && ef == 2'd0) begin
      int vic;
      vic = -1;
      for (int i = 0; i < ENT; i++) if (vic < 0 && !m_v[i]) vic = i;
      if (vic < 0) begin vic = m_rr; m_rr = (m_rr + 1) % ENT; end
      m_v[vic] = 1; m_vpn[vic] = 4'(vpn); m_asid[vic] = cur_asid;
      m_pfn[vic] = epfn; m_w[vic] = pte[1]; m_u[vic] = pte[2];
    end
  endtask

  task automatic do_flush(input bit all, input bit one, input int sp);
    @(negedge clk);
    flush_all = all; flush_asid_en = one; flush_asid = AS'(sp);
    @(negedge clk);
    flush_all = 1'b0; flush_asid_en = 1'b0;
    for (int i = 0; i < ENT; i++)
      if (all || (one && m_asid[i] == AS'(sp))) m_v[i] = 0;
  endtask

  task automatic set_space(input int sp);
    @(negedge clk);
    cur_asid = AS'(sp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < ENT; i++) m_v[i] = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(!rsp_valid, "R13", "rsp_valid in reset", int'(rsp_valid), 0);
    chk(!mem_req_valid, "R13", "mem_req_valid in reset", int'(mem_req_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(!rsp_valid && !req_ready, "R13", "no response after reset",
        int'(rsp_valid | req_ready), 0);
    chk(!mem_req_valid, "R13", "no read after reset", int'(mem_req_valid), 0);

    // First touch of a page must read the table (nothing cached after reset).
    access(1, 4, 0, 0, 0, "R13");
    access(1, 9, 0, 0, 0, "R6");        // now cached
    access(1, 2, 0, 1, 0, "R2");        // page 1 refuses user mode
    access(3, 0, 1, 0, 0, "R5");        // page 3 refuses writes on fetch
    access(3, 1, 1, 0, 0, "R5");        // not cached: reads again
    access(4, 7, 0, 0, 0, "R4");        // page 4 invalid
    access(4, 7, 0, 0, 0, "R4");        // not cached: reads again
    access(2, 5, 1, 1, 0, "R6");
    access(2, 5, 1, 1, 1, "R12");       // hit under stall

    // Address-space tagging.
    set_space(1);
    access(1, 3, 0, 0, 0, "R7");
    access(1, 3, 0, 0, 0, "R7");
    set_space(0);
    access(1, 3, 0, 0, 0, "R7");

    // Flush by address space.
    do_flush(0, 1, 0);
    set_space(1);
    access(1, 6, 0, 0, 0, "R9");
    set_space(0);
    access(1, 6, 0, 0, 0, "R9");
    access(2, 6, 0, 0, 0, "R9");

    // Full flush.
    do_flush(1, 0, 0);
    access(1, 6, 0, 0, 0, "R8");

    // Replacement order: fill, then evict round robin.
    do_flush(1, 0, 0);
    for (int v = 0; v < 4; v++) access(v, 1, 0, 0, 0, "R10");
    access(5, 1, 0, 0, 0, "R10");
    access(1, 1, 0, 0, 0, "R10");
    access(0, 1, 0, 0, 0, "R10");
    access(1, 1, 0, 0, 0, "R10");
    access(5, 1, 0, 0, 0, "R10");

    // Moved table base: new reads use it, cached entries persist.
    @(negedge clk);
    ptbase = 16'h0130;
    access(7, 2, 0, 1, 0, "R3");
    access(5, 2, 0, 0, 0, "R3");

    // Sweep: every page, both spaces, rotating access kinds.
    for (int pass = 0; pass < 3; pass++) begin
      for (int sp = 0; sp < 2; sp++) begin
        set_space(sp);
        for (int v = 0; v < 16; v++) begin
          int md;
          md = (v + pass + sp) % 4;
          access(v, (v * 5 + pass) % 16, md[0], md[1], (v % 7) == 0, "R6");
        end
      end
      if (pass == 1) do_flush(0, 1, 1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule